// File: doc/BRIEF.md
# MII Virtual PHY Loopback Router

This block joins an external MAC port to an internal switch-engine port. Both sides use MII-style nibble signals: a transmit enable with a 4-bit transmit nibble, a receive data-valid with a 4-bit receive nibble, carrier sense and collision. In normal operation it acts as two PHYs wired back to back. Each side's transmit stream appears on the other side's receive pins one clock later, and carrier sense on both sides shows activity from either transmitter.

A set of static control inputs places the router in a test configuration:
- Either side can be looped back onto itself. Each loopback discards what the opposite side transmits.
- Collision can be injected toward the switch engine whenever the switch engine transmits.
- The MAC-facing receive side can be isolated.
- An RMII flag suppresses the heartbeat and the MAC-side collision test.

Outside RMII mode, a signal-quality heartbeat pulse is sent back on the MAC's collision line after each MAC transmission. A status output reports the resulting mode.

Top module: `vphy_loop_router`

## Requirements
- R1: With no loopback and no isolation, mac_rx_dv/mac_rxd equal sw_tx_en/sw_txd from the previous cycle, and sw_rx_dv/sw_rxd equal mac_tx_en/mac_txd from the previous cycle.
- R2: Each side's crs is high in a cycle when, one cycle earlier, that side was transmitting or the receive data-valid being delivered to it was being formed. In normal mode this means either side was transmitting.
- R3: With cfg_mac_loop set, mac_rx_dv/mac_rxd return the previous cycle's mac_tx_en/mac_txd, sw_tx data never reaches mac_rxd, and sw_rx_dv stays low unless cfg_sw_loop is also set.
- R4: With cfg_sw_loop set, sw_rx_dv/sw_rxd return the previous cycle's sw_tx_en/sw_txd, and MAC transmit data never reaches the switch side.
- R5: With both loopback bits set, each side receives only its own transmit stream, and nothing crosses between the sides.
- R6: With cfg_sw_coltest set, sw_col equals sw_tx_en of the previous cycle, whatever the isolate and loopback settings. With it clear, sw_col stays low.
- R7: When cfg_isolate is set and neither cfg_sw_loop nor cfg_sw_coltest is set, mac_rx_dv, mac_rxd, mac_crs and mac_col are all low. The switch side keeps working.
- R8: Outside RMII mode, if mac_tx_en is high in one cycle and low in the next (cycle k), mac_col is high for SQE_LEN cycles starting SQE_GAP cycles after cycle k. Any new mac_tx_en before or during that pulse cancels it.
- R9: With cfg_rmii set, no heartbeat is produced and cfg_mac_coltest has no effect, so mac_col stays low.
- R10: With cfg_mac_coltest set outside RMII mode, mac_col equals mac_tx_en of the previous cycle, in addition to any heartbeat.
- R11: st_mode encodes the active mode as follows:
  - 4: isolated (the R7 condition), which takes precedence over the others
  - 3: both loopbacks
  - 2: switch loopback
  - 1: MAC loopback
  - 0: normal
- R12: While rst_n is low at a clock edge, all receive, crs and col outputs are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both nibble interfaces |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mac_loop | input | 1 | Loop MAC transmit back to MAC receive |
| cfg_sw_loop | input | 1 | Loop switch transmit back to switch receive |
| cfg_sw_coltest | input | 1 | Inject collision toward switch on its transmit |
| cfg_mac_coltest | input | 1 | Assert MAC collision on MAC transmit (not in RMII) |
| cfg_isolate | input | 1 | Silence the MAC-facing receive side |
| cfg_rmii | input | 1 | RMII flag: no heartbeat, no MAC collision test |
| mac_tx_en | input | 1 | MAC transmit enable |
| mac_txd | input | NIB_W | MAC transmit nibble |
| mac_rx_dv | output | 1 | Receive data valid toward MAC |
| mac_rxd | output | NIB_W | Receive nibble toward MAC |
| mac_crs | output | 1 | Carrier sense toward MAC |
| mac_col | output | 1 | Collision / heartbeat toward MAC |
| sw_tx_en | input | 1 | Switch-engine transmit enable |
| sw_txd | input | NIB_W | Switch-engine transmit nibble |
| sw_rx_dv | output | 1 | Receive data valid toward switch |
| sw_rxd | output | NIB_W | Receive nibble toward switch |
| sw_crs | output | 1 | Carrier sense toward switch |
| sw_col | output | 1 | Collision toward switch |
| st_mode | output | 3 | Active mode code (R11) |

## Verification
The bench drives both transmitters at once with different nibbles in each loopback mode. A router that routed the wrong source, or let the silenced side leak through, therefore shows the wrong nibble on a receive port.

The heartbeat is timed cycle by cycle from the fall of MAC transmit, and then restarted transmit inside the wait window. A wrong gap or length shifts or stretches the mac_col pulse, and a missing cancel leaves a stray pulse in the middle of a frame.

The switch collision test is combined with isolation and with switch loopback, because a design that let isolation win would drop sw_col. RMII mode is checked with the MAC collision test on, where a design that ignored the flag would raise mac_col.

// File: rtl/vphy_pkg.sv
// Shared types for the MII virtual PHY loopback router.
package vphy_pkg;

    // Mode code reported on st_mode; the numbers are part of the port contract.
    typedef enum logic [2:0] {
        MODE_NORMAL    = 3'd0,
        MODE_MAC_LOOP  = 3'd1,
        MODE_SW_LOOP   = 3'd2,
        MODE_DUAL_LOOP = 3'd3,
        MODE_ISOLATED  = 3'd4
    } vphy_mode_e;

    // States of the heartbeat generator.
    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_WAIT  = 2'd1,
        HB_PULSE = 2'd2
    } hb_state_e;

    // Static configuration bundle.
    typedef struct packed {
        logic mac_loop;
        logic sw_loop;
        logic sw_coltest;
        logic mac_coltest;
        logic isolate;
        logic rmii;
    } vphy_cfg_t;

endpackage

// File: rtl/vphy_mode_decode.sv
// Decodes the configuration into the MAC-side silence condition and the
// reported mode code. Purely combinational; assumes cfg is quasi-static.
module vphy_mode_decode
    import vphy_pkg::*;
(
    input  vphy_cfg_t  cfg,
    output logic       mac_quiet,
    output vphy_mode_e mode
);

    // Isolation silences the MAC side unless a switch-side test is running.
    assign mac_quiet = cfg.isolate & ~cfg.sw_loop & ~cfg.sw_coltest;

    // Priority encode the mode: isolation, then loopback combinations.
    always_comb begin
        if (mac_quiet)
            mode = MODE_ISOLATED;
        else if (cfg.mac_loop && cfg.sw_loop)
            mode = MODE_DUAL_LOOP;
        else if (cfg.sw_loop)
            mode = MODE_SW_LOOP;
        else if (cfg.mac_loop)
            mode = MODE_MAC_LOOP;
        else
            mode = MODE_NORMAL;
    end

endmodule

// File: rtl/vphy_nibble_route.sv
// One receive direction: picks the stream delivered to a side's receive
// pins and registers it with carrier sense. loop_sel returns the side's own
// transmit stream; otherwise block_sel silences the far stream (the far
// side is in its own loopback); otherwise the far stream is forwarded.
module vphy_nibble_route #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loop_sel,
    input  logic             block_sel,
    input  logic             own_en,
    input  logic [NIB_W-1:0] own_d,
    input  logic             far_en,
    input  logic [NIB_W-1:0] far_d,
    output logic             rx_dv,
    output logic [NIB_W-1:0] rx_d,
    output logic             crs
);

    logic             nxt_dv;
    logic [NIB_W-1:0] nxt_d;

    // Select the source stream for this receive path.
    always_comb begin
        if (loop_sel) begin
            nxt_dv = own_en;
            nxt_d  = own_d;
        end else if (block_sel) begin
            nxt_dv = 1'b0;
            nxt_d  = '0;
        end else begin
            nxt_dv = far_en;
            nxt_d  = far_d;
        end
    end

    // Register the receive stream and carrier sense for a one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_dv <= 1'b0;
            rx_d  <= '0;
            crs   <= 1'b0;
        end else begin
            rx_dv <= nxt_dv;
            rx_d  <= nxt_d;
            crs   <= own_en | nxt_dv;
        end
    end

endmodule

// File: rtl/vphy_sqe_gen.sv
// Heartbeat generator: after the MAC's transmit enable falls, waits GAP
// cycles and then raises hb for LEN cycles. New transmit activity or the
// RMII flag returns it to idle at once. Assumes GAP >= 1 and LEN >= 1.
module vphy_sqe_gen
    import vphy_pkg::*;
#(
    parameter int GAP = 4,
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic rmii,
    output logic hb
);

    localparam int SPAN = (GAP > LEN) ? GAP : LEN;
    localparam int CW   = $clog2(SPAN + 1);

    hb_state_e       state;
    logic [CW-1:0]   cnt;
    logic            tx_prev;

    // Remember last cycle's transmit enable to spot its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_prev <= 1'b0;
        else        tx_prev <= tx_en;
    end

    // Sequence wait window and pulse, cancelling on any new transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HB_IDLE;
            cnt   <= '0;
        end else if (tx_en || rmii) begin
            state <= HB_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                HB_IDLE: if (tx_prev) begin
                    state <= HB_WAIT;
                    cnt   <= CW'(GAP - 1);
                end
                HB_WAIT: if (cnt == '0) begin
                    state <= HB_PULSE;
                    cnt   <= CW'(LEN - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                HB_PULSE: if (cnt == '0) begin
                    state <= HB_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: state <= HB_IDLE;
            endcase
        end
    end

    assign hb = (state == HB_PULSE);

endmodule

// File: rtl/vphy_loop_router.sv
// Top of the MII virtual PHY loopback router. Cross-connects a MAC-side and
// a switch-side nibble interface with one cycle of latency, applies the
// loopback, isolation and collision-test settings, and emits the heartbeat.
// Assumes the cfg_* inputs change only between frames.
module vphy_loop_router
    import vphy_pkg::*;
#(
    parameter int NIB_W   = 4,
    parameter int SQE_GAP = 4,
    parameter int SQE_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mac_loop,
    input  logic             cfg_sw_loop,
    input  logic             cfg_sw_coltest,
    input  logic             cfg_mac_coltest,
    input  logic             cfg_isolate,
    input  logic             cfg_rmii,
    input  logic             mac_tx_en,
    input  logic [NIB_W-1:0] mac_txd,
    output logic             mac_rx_dv,
    output logic [NIB_W-1:0] mac_rxd,
    output logic             mac_crs,
    output logic             mac_col,
    input  logic             sw_tx_en,
    input  logic [NIB_W-1:0] sw_txd,
    output logic             sw_rx_dv,
    output logic [NIB_W-1:0] sw_rxd,
    output logic             sw_crs,
    output logic             sw_col,
    output logic [2:0]       st_mode
);

    vphy_cfg_t        cfg;
    vphy_mode_e       mode;
    logic             mac_quiet;
    logic             m_dv, m_crs, hb;
    logic [NIB_W-1:0] m_d;
    logic             mac_ct_q, sw_col_q;

    // Bundle the configuration pins.
    assign cfg = '{mac_loop: cfg_mac_loop, sw_loop: cfg_sw_loop,
                   sw_coltest: cfg_sw_coltest, mac_coltest: cfg_mac_coltest,
                   isolate: cfg_isolate, rmii: cfg_rmii};

    vphy_mode_decode u_dec (
        .cfg       (cfg),
        .mac_quiet (mac_quiet),
        .mode      (mode)
    );

    // Receive path toward the MAC.
    vphy_nibble_route #(.NIB_W(NIB_W)) u_to_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .loop_sel  (cfg.mac_loop),
        .block_sel (cfg.sw_loop),
        .own_en    (mac_tx_en),
        .own_d     (mac_txd),
        .far_en    (sw_tx_en),
        .far_d     (sw_txd),
        .rx_dv     (m_dv),
        .rx_d      (m_d),
        .crs       (m_crs)
    );

    // Receive path toward the switch engine.
    vphy_nibble_route #(.NIB_W(NIB_W)) u_to_sw (
        .clk       (clk),
        .rst_n     (rst_n),
        .loop_sel  (cfg.sw_loop),
        .block_sel (cfg.mac_loop),
        .own_en    (sw_tx_en),
        .own_d     (sw_txd),
        .far_en    (mac_tx_en),
        .far_d     (mac_txd),
        .rx_dv     (sw_rx_dv),
        .rx_d      (sw_rxd),
        .crs       (sw_crs)
    );

    vphy_sqe_gen #(.GAP(SQE_GAP), .LEN(SQE_LEN)) u_sqe (
        .clk   (clk),
        .rst_n (rst_n),
        .tx_en (mac_tx_en),
        .rmii  (cfg.rmii),
        .hb    (hb)
    );

    // Register both collision-test sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mac_ct_q <= 1'b0;
            sw_col_q <= 1'b0;
        end else begin
            mac_ct_q <= cfg.mac_coltest & ~cfg.rmii & mac_tx_en;
            sw_col_q <= cfg.sw_coltest & sw_tx_en;
        end
    end

    // Apply MAC-side isolation to everything the MAC sees.
    assign mac_rx_dv = m_dv & ~mac_quiet;
    assign mac_rxd   = mac_quiet ? '0 : m_d;
    assign mac_crs   = m_crs & ~mac_quiet;
    assign mac_col   = (mac_ct_q | hb) & ~mac_quiet;
    assign sw_col    = sw_col_q;
    assign st_mode   = mode;

endmodule

// File: rtl/vphy_loop_router_chk.sv
// Assertion checker for vphy_loop_router, attached by bind below.
module vphy_loop_router_chk #(
    parameter int NIB_W   = 4,
    parameter int SQE_LEN = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_mac_loop,
    input logic             cfg_sw_loop,
    input logic             cfg_sw_coltest,
    input logic             cfg_mac_coltest,
    input logic             cfg_isolate,
    input logic             cfg_rmii,
    input logic             mac_tx_en,
    input logic [NIB_W-1:0] mac_txd,
    input logic             mac_rx_dv,
    input logic [NIB_W-1:0] mac_rxd,
    input logic             mac_crs,
    input logic             mac_col,
    input logic             sw_tx_en,
    input logic [NIB_W-1:0] sw_txd,
    input logic             sw_rx_dv,
    input logic [NIB_W-1:0] sw_rxd,
    input logic             sw_col
);

    logic       seen;
    logic       quiet;
    logic [7:0] hb_run;

    // Mark that at least one cycle has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // Length of the current run of heartbeat-only collision.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hb_run <= '0;
        else if (mac_col && !cfg_mac_coltest)
            hb_run <= (hb_run == 8'hFF) ? hb_run : hb_run + 1'b1;
        else
            hb_run <= '0;
    end

    assign quiet = cfg_isolate & ~cfg_sw_loop & ~cfg_sw_coltest;

    assert_mac_echo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && cfg_mac_loop && $past(cfg_mac_loop) && !quiet)
        |-> (mac_rx_dv == $past(mac_tx_en) && mac_rxd == $past(mac_txd)));

    assert_sw_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && cfg_sw_loop && $past(cfg_sw_loop))
        |-> (sw_rx_dv == $past(sw_tx_en) && sw_rxd == $past(sw_txd)));

    assert_sw_coltest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && cfg_sw_coltest == $past(cfg_sw_coltest))
        |-> (sw_col == (cfg_sw_coltest & $past(sw_tx_en))));

    assert_isolate_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> (!mac_rx_dv && !mac_crs && !mac_col && mac_rxd == '0));

    assert_hb_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hb_run <= 8'(SQE_LEN));

    assert_rmii_no_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && cfg_rmii && $past(cfg_rmii)) |-> !mac_col);

endmodule

bind vphy_loop_router vphy_loop_router_chk #(.NIB_W(NIB_W), .SQE_LEN(SQE_LEN)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_mac_loop    (cfg_mac_loop),
    .cfg_sw_loop     (cfg_sw_loop),
    .cfg_sw_coltest  (cfg_sw_coltest),
    .cfg_mac_coltest (cfg_mac_coltest),
    .cfg_isolate     (cfg_isolate),
    .cfg_rmii        (cfg_rmii),
    .mac_tx_en       (mac_tx_en),
    .mac_txd         (mac_txd),
    .mac_rx_dv       (mac_rx_dv),
    .mac_rxd         (mac_rxd),
    .mac_crs         (mac_crs),
    .mac_col         (mac_col),
    .sw_tx_en        (sw_tx_en),
    .sw_txd          (sw_txd),
    .sw_rx_dv        (sw_rx_dv),
    .sw_rxd          (sw_rxd),
    .sw_col          (sw_col)
);

// File: tb/vphy_loop_router_test.sv
// Scoreboard bench: step() drives one cycle and queues the expected
// outputs; the monitor pops and compares them after the next rising edge.
module vphy_loop_router_test;

    localparam int GAP = 4;
    localparam int LEN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_mac_loop = 0, cfg_sw_loop = 0, cfg_sw_coltest = 0;
    logic cfg_mac_coltest = 0, cfg_isolate = 0, cfg_rmii = 0;
    logic mac_tx_en = 0, sw_tx_en = 0;
    logic [3:0] mac_txd = 0, sw_txd = 0;
    logic mac_rx_dv, mac_crs, mac_col, sw_rx_dv, sw_crs, sw_col;
    logic [3:0] mac_rxd, sw_rxd;
    logic [2:0] st_mode;

    // Shadow configuration, applied to the design inside step().
    logic c_ml = 0, c_sl = 0, c_sct = 0, c_mct = 0, c_iso = 0, c_rmii = 0;

    int checks = 0;
    int failures = 0;
    int since = -1;
    logic prev_mte = 1'b0;
    logic done = 1'b0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    vphy_loop_router #(.NIB_W(4), .SQE_GAP(GAP), .SQE_LEN(LEN)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_mac_loop(cfg_mac_loop), .cfg_sw_loop(cfg_sw_loop),
        .cfg_sw_coltest(cfg_sw_coltest), .cfg_mac_coltest(cfg_mac_coltest),
        .cfg_isolate(cfg_isolate), .cfg_rmii(cfg_rmii),
        .mac_tx_en(mac_tx_en), .mac_txd(mac_txd),
        .mac_rx_dv(mac_rx_dv), .mac_rxd(mac_rxd), .mac_crs(mac_crs), .mac_col(mac_col),
        .sw_tx_en(sw_tx_en), .sw_txd(sw_txd),
        .sw_rx_dv(sw_rx_dv), .sw_rxd(sw_rxd), .sw_crs(sw_crs), .sw_col(sw_col),
        .st_mode(st_mode)
    );

    function automatic logic [16:0] actual_vec();
        return {mac_rx_dv, mac_rxd, mac_crs, mac_col,
                sw_rx_dv, sw_rxd, sw_crs, sw_col, st_mode};
    endfunction

    // Drive one cycle of stimulus and queue the outputs it must produce.
    task automatic step(input logic mte, input logic [3:0] mtd,
                        input logic ste, input logic [3:0] std, input string tag);
        logic q, mdv, mcrs, mcol, sdv, scrs, scol, hb;
        logic [3:0] mrd, srd;
        logic [2:0] md;
        @(negedge clk);
        cfg_mac_loop = c_ml; cfg_sw_loop = c_sl; cfg_sw_coltest = c_sct;
        cfg_mac_coltest = c_mct; cfg_isolate = c_iso; cfg_rmii = c_rmii;
        mac_tx_en = mte; mac_txd = mtd; sw_tx_en = ste; sw_txd = std;
        q = c_iso & ~c_sl & ~c_sct;
        if (c_ml)      begin mdv = mte;  mrd = mtd; end
        else if (c_sl) begin mdv = 1'b0; mrd = 4'h0; end
        else           begin mdv = ste;  mrd = std; end
        mcrs = mte | mdv;
        if (c_sl)      begin sdv = ste;  srd = std; end
        else if (c_ml) begin sdv = 1'b0; srd = 4'h0; end
        else           begin sdv = mte;  srd = mtd; end
        scrs = ste | sdv;
        scol = c_sct & ste;
        if (mte || c_rmii)              since = -1;
        else if (prev_mte)              since = 0;
        else if (since >= 0 && since < 1000) since++;
        prev_mte = mte;
        hb = (since >= GAP) && (since < GAP + LEN);
        mcol = (c_mct & ~c_rmii & mte) | hb;
        if (q) begin mdv = 0; mrd = 0; mcrs = 0; mcol = 0; end
        if (q)               md = 3'd4;
        else if (c_ml && c_sl) md = 3'd3;
        else if (c_sl)       md = 3'd2;
        else if (c_ml)       md = 3'd1;
        else                 md = 3'd0;
        exp_q.push_back({mdv, mrd, mcrs, mcol, sdv, srd, scrs, scol, md});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 4'h0, 1'b0, 4'h0, tag);
    endtask

    // Monitor: compare each queued expectation just after its clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [16:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (actual_vec() !== e) begin
                    failures++;
                    $display("FAIL %s actual=%05h expected=%05h", t, actual_vec(), e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #4000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R12: reset clears outputs.
        mac_tx_en = 1; mac_txd = 4'hA; sw_tx_en = 1; sw_txd = 4'h5;
        repeat (3) @(posedge clk);
        #5;
        checks++;
        if ({mac_rx_dv, mac_rxd, mac_crs, mac_col, sw_rx_dv, sw_rxd, sw_crs, sw_col} !== 12'h0) begin
            failures++;
            $display("FAIL R12 actual=%03h expected=000",
                     {mac_rx_dv, mac_rxd, mac_crs, mac_col, sw_rx_dv, sw_rxd, sw_crs, sw_col});
        end
        @(negedge clk);
        mac_tx_en = 0; mac_txd = 0; sw_tx_en = 0; sw_txd = 0;
        rst_n = 1'b1;

        // R1: normal cross-connect, MAC to switch then switch to MAC.
        for (int i = 1; i < 6; i++) step(1'b1, 4'(i), 1'b0, 4'h0, "R1");
        idle(2, "R1");
        for (int i = 0; i < 4; i++) step(1'b0, 4'h0, 1'b1, 4'(9 + i), "R1");
        // R2: both transmit, carrier on both sides.
        for (int i = 0; i < 3; i++) step(1'b1, 4'(3 + i), 1'b1, 4'(12 - i), "R2");
        step(1'b0, 4'h0, 1'b1, 4'h7, "R2");
        // R8: heartbeat after MAC transmit ends.
        idle(10, "R8");
        for (int i = 0; i < 3; i++) step(1'b1, 4'hC, 1'b0, 4'h0, "R8");
        idle(GAP + LEN + 3, "R8");
        // R8: restart inside the wait window cancels the heartbeat.
        step(1'b1, 4'h1, 1'b0, 4'h0, "R8");
        idle(GAP - 1, "R8");
        step(1'b1, 4'h2, 1'b0, 4'h0, "R8");
        idle(GAP + 1, "R8");
        // R8: restart during the pulse.
        step(1'b1, 4'h3, 1'b0, 4'h0, "R8");
        idle(GAP + 1, "R8");
        step(1'b1, 4'h4, 1'b0, 4'h0, "R8");
        idle(GAP + LEN + 2, "R8");
        // R10: MAC collision test outside RMII.
        c_mct = 1;
        for (int i = 0; i < 3; i++) step(1'b1, 4'h6, 1'b0, 4'h0, "R10");
        idle(GAP + LEN + 2, "R10");
        // R9: RMII suppresses heartbeat and MAC collision test.
        c_rmii = 1;
        idle(1, "R9");
        for (int i = 0; i < 3; i++) step(1'b1, 4'h8, 1'b0, 4'h0, "R9");
        idle(GAP + LEN + 2, "R9");
        c_mct = 0; c_rmii = 0;
        idle(1, "R9");
        // R3: MAC loopback with both sides transmitting.
        c_ml = 1;
        idle(1, "R3");
        for (int i = 0; i < 4; i++) step(1'b1, 4'(2 * i + 1), 1'b1, 4'(14 - i), "R3");
        idle(GAP + LEN + 2, "R3");
        // R4: switch loopback with both sides transmitting.
        c_ml = 0; c_sl = 1;
        idle(1, "R4");
        for (int i = 0; i < 4; i++) step(1'b1, 4'(i + 4), 1'b1, 4'(15 - 2 * i), "R4");
        idle(GAP + LEN + 2, "R4");
        // R5: both loopbacks, nothing crosses.
        c_ml = 1;
        idle(1, "R5");
        for (int i = 0; i < 4; i++) step(1'b1, 4'(i + 1), 1'b1, 4'(10 + i), "R5");
        step(1'b0, 4'h0, 1'b1, 4'hF, "R5");
        idle(GAP + LEN + 2, "R5");
        // R6: switch collision test under switch loopback, then under isolate.
        c_ml = 0; c_sct = 1;
        for (int i = 0; i < 4; i++) step(1'b0, 4'h0, (i % 2) == 0, 4'h9, "R6");
        c_sl = 0; c_iso = 1;
        for (int i = 0; i < 4; i++) step(1'b1, 4'h2, (i % 2) == 1, 4'h5, "R6");
        idle(GAP + LEN + 2, "R6");
        c_sct = 0; c_sl = 1;
        for (int i = 0; i < 3; i++) step(1'b0, 4'h0, 1'b1, 4'h3, "R6");
        // R7: isolation without switch tests silences the MAC side.
        c_sl = 0;
        idle(1, "R7");
        for (int i = 0; i < 4; i++) step(1'b1, 4'(i + 7), 1'b1, 4'hE, "R7");
        idle(GAP + LEN + 2, "R7");
        c_ml = 1;
        for (int i = 0; i < 3; i++) step(1'b1, 4'hB, 1'b0, 4'h0, "R7");
        idle(GAP + LEN + 2, "R7");
        // R11: walk the mode encodings.
        c_ml = 0; c_iso = 0; idle(2, "R11");
        c_ml = 1;            idle(2, "R11");
        c_sl = 1;            idle(2, "R11");
        c_ml = 0;            idle(2, "R11");
        c_iso = 1;           idle(2, "R11");
        c_sl = 0;            idle(2, "R11");
        c_sct = 1;           idle(2, "R11");
        c_sct = 0; c_iso = 0; idle(2, "R11");

        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule